// File: doc/BRIEF.md
# Half-Group Memory Access Coalescer

This block takes the byte addresses issued by one group of 16 lanes and folds them into the fewest aligned memory transactions. A group arrives in one beat: sixteen addresses, a mask of active lanes, a word-size code and a mode select. The beat is accepted with a valid/ready handshake. The block then emits one transaction per cycle. Each transaction carries an aligned base address, a size given as log2 of its byte count, and the mask of lanes it serves. A done pulse marks the cycle in which the group has been fully issued.

Two rule sets are offered. In relaxed mode, lanes that fall in the same aligned segment share one transaction, whatever their order. The segment size depends on the word size, and each transaction is then cut down to the smallest aligned power-of-two window of at least 32 bytes that still covers every byte the served lanes touch. In strict mode, the group merges only when every active lane k addresses word k of a block aligned to sixteen words. Any other pattern is issued lane by lane.

Top module: `mcoal_top`

## Requirements
- R1: After reset, `in_ready` is 1 and `txn_valid` and `grp_done` are 0.
- R2: A group is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge through the cycle that shows `grp_done`, and is 1 again in the following cycle.
- R3: In relaxed mode, the segment is 32 bytes for code 0, 64 bytes for code 1, and 128 bytes for codes 2, 3 and 4. All active lanes inside one aligned segment are served by one transaction, regardless of lane order.
- R4: A relaxed transaction has the smallest size 2^s (5 <= s <= segment log2) such that one aligned window of 2^s bytes holds every byte touched by its lanes. Its base is that window's start.
- R5: Transactions come out one per cycle, starting in the cycle after acceptance. They are ordered by the lowest-numbered still-pending active lane, and each one includes that lane.
- R6: Every active lane appears in exactly one transaction mask. Inactive lanes appear in none, and their addresses have no effect.
- R7: In strict mode, if each active lane k has word address B + k*W, where B is aligned to 16*W, one transaction is issued with base B, size 16*W and mask equal to the active mask. For 16-byte words this covers 256 bytes, i.e. two adjacent 128-byte segments.
- R8: In strict mode, any other pattern issues one transaction per active lane, in ascending lane order. Each has size W, base equal to that lane's word address, and a one-lane mask.
- R9: A group with no active lane shows `grp_done` in the cycle after acceptance, with no transaction.
- R10: `grp_done` is 1 exactly in the cycle of the group's last transaction.
- R11: Word-size code c in 0..4 means W = 2^c bytes. Address bits below log2(W) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Block can take a group |
| in_addr | input | 512 | Lane k byte address in bits [32k+31:32k] |
| in_mask | input | 16 | Active lanes |
| in_wcode | input | 3 | Word size code (W = 2^code bytes, 0..4) |
| in_strict | input | 1 | 1 selects strict rules, 0 relaxed |
| txn_valid | output | 1 | Transaction present this cycle |
| txn_base | output | 32 | Aligned transaction base address |
| txn_lg | output | 4 | log2 of transaction size in bytes |
| txn_mask | output | 16 | Lanes served by this transaction |
| grp_done | output | 1 | Group fully issued |

## Verification
The assertions assume that the word-size code never exceeds 4 when a group is offered. The bench only ever drives codes 0 to 4. They also assume that the active lanes of a strict-mode group do not wrap around the top of the address space. Every stimulus address sits far below that limit. No transaction has backpressure, so the properties take each emitted transaction as consumed in the cycle it appears. The bench therefore samples every cycle between acceptance and done, and never stalls.

// File: rtl/mcoal_pkg.sv
package mcoal_pkg;
  parameter int ADDR_W   = 32;
  parameter int LANES    = 16;
  parameter int MIN_LG   = 5;
  parameter int MAX_SEG  = 7;
  localparam int LIDX_W  = $clog2(LANES);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LANES-1:0]  lmask_t;

  // clear the low lg bits of an address
  function automatic addr_t align_down(input addr_t a, input logic [3:0] lg);
    return a & ~((addr_t'(1) << lg) - addr_t'(1));
  endfunction

  // relaxed segment size (log2 bytes) for a word-size code
  function automatic logic [3:0] seg_lg(input logic [2:0] code);
    case (code)
      3'd0:    return 4'(MIN_LG);
      3'd1:    return 4'(MIN_LG + 1);
      default: return 4'(MAX_SEG);
    endcase
  endfunction

  // isolate the lowest set lane
  function automatic lmask_t low_onehot(input lmask_t m);
    return m & (~m + lmask_t'(1));
  endfunction
endpackage

// File: rtl/mcoal_member.sv
module mcoal_member
  import mcoal_pkg::*;
(
  input  addr_t      lane_addr [LANES],
  input  lmask_t     pend,
  input  addr_t      lead_addr,
  input  logic [3:0] sg_lg,
  output lmask_t     members
);
  addr_t lead_seg;
  assign lead_seg = align_down(lead_addr, sg_lg);

  for (genvar k = 0; k < LANES; k++) begin : g_cmp
    assign members[k] = pend[k] && (align_down(lane_addr[k], sg_lg) == lead_seg);
  end
endmodule

// File: rtl/mcoal_shrink.sv
module mcoal_shrink
  import mcoal_pkg::*;
(
  input  addr_t      lane_addr [LANES],
  input  lmask_t     members,
  input  logic [2:0] wlg,
  input  logic [3:0] sg_lg,
  output addr_t      win_base,
  output logic [3:0] win_lg
);
  addr_t lo, hi, wa, we;

  always_comb begin
    lo = '1;
    hi = '0;
    for (int k = 0; k < LANES; k++) begin
      wa = align_down(lane_addr[k], {1'b0, wlg});
      we = wa + ((addr_t'(1) << wlg) - addr_t'(1));
      if (members[k]) begin
        if (wa < lo) lo = wa;
        if (we > hi) hi = we;
      end
    end
    win_lg = sg_lg;
    for (int s = MAX_SEG; s >= MIN_LG; s--) begin
      if ((4'(s) <= sg_lg) && ((lo >> s) == (hi >> s))) win_lg = 4'(s);
    end
    win_base = align_down(lo, win_lg);
  end
endmodule

// File: rtl/mcoal_strict.sv
module mcoal_strict
  import mcoal_pkg::*;
(
  input  addr_t      lane_addr [LANES],
  input  lmask_t     act,
  input  logic [2:0] wlg,
  output logic       seq_ok,
  output addr_t      seq_base
);
  logic [LIDX_W-1:0] lead;

  always_comb begin
    lead = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (act[k]) lead = LIDX_W'(k);
    end
    seq_base = align_down(lane_addr[lead], {1'b0, wlg}) - (addr_t'(lead) << wlg);
    seq_ok   = (act != '0) && (align_down(seq_base, {1'b0, wlg} + 4'd4) == seq_base);
    for (int k = 0; k < LANES; k++) begin
      if (act[k] && (align_down(lane_addr[k], {1'b0, wlg}) != seq_base + (addr_t'(k) << wlg)))
        seq_ok = 1'b0;
    end
  end
endmodule

// File: rtl/mcoal_top.sv
module mcoal_top
  import mcoal_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_mask,
  input  logic [2:0]              in_wcode,
  input  logic                    in_strict,
  output logic                    txn_valid,
  output logic [ADDR_W-1:0]       txn_base,
  output logic [3:0]              txn_lg,
  output logic [LANES-1:0]        txn_mask,
  output logic                    grp_done
);
  addr_t             in_lane [LANES];
  addr_t             addr_q  [LANES];
  lmask_t            rem_q, lead_oh, members, take;
  logic [2:0]        wlg_q;
  logic              strict_q, sok_q, busy_q, accept;
  addr_t             sbase_q, s_base, lead_addr, shr_base;
  logic              s_ok;
  logic [3:0]        sglg, shr_lg;
  logic [LIDX_W-1:0] lead_idx;

  for (genvar k = 0; k < LANES; k++) begin : g_unpack
    assign in_lane[k] = in_addr[k*ADDR_W +: ADDR_W];
  end

  // strict pattern test runs on the incoming beat
  mcoal_strict u_strict (
    .lane_addr(in_lane), .act(in_mask), .wlg(in_wcode),
    .seq_ok(s_ok), .seq_base(s_base)
  );

  assign in_ready = !busy_q;
  assign accept   = in_valid && in_ready;

  // leader: lowest pending lane
  assign lead_oh = low_onehot(rem_q);
  always_comb begin
    lead_idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (rem_q[k]) lead_idx = LIDX_W'(k);
    end
  end
  assign lead_addr = addr_q[lead_idx];
  assign sglg      = seg_lg(wlg_q);

  mcoal_member u_member (
    .lane_addr(addr_q), .pend(rem_q), .lead_addr(lead_addr),
    .sg_lg(sglg), .members(members)
  );

  mcoal_shrink u_shrink (
    .lane_addr(addr_q), .members(members), .wlg(wlg_q),
    .sg_lg(sglg), .win_base(shr_base), .win_lg(shr_lg)
  );

  always_comb begin
    if (strict_q && sok_q) begin
      take     = rem_q;
      txn_base = sbase_q;
      txn_lg   = {1'b0, wlg_q} + 4'd4;
    end else if (strict_q) begin
      take     = lead_oh;
      txn_base = align_down(lead_addr, {1'b0, wlg_q});
      txn_lg   = {1'b0, wlg_q};
    end else begin
      take     = members;
      txn_base = shr_base;
      txn_lg   = shr_lg;
    end
  end

  assign txn_mask  = take;
  assign txn_valid = busy_q && (rem_q != '0);
  assign grp_done  = busy_q && ((rem_q & ~take) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rem_q    <= '0;
      wlg_q    <= '0;
      strict_q <= 1'b0;
      sok_q    <= 1'b0;
      sbase_q  <= '0;
      for (int k = 0; k < LANES; k++) addr_q[k] <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      rem_q    <= in_mask;
      wlg_q    <= in_wcode;
      strict_q <= in_strict;
      sok_q    <= s_ok;
      sbase_q  <= s_base;
      for (int k = 0; k < LANES; k++) addr_q[k] <= in_lane[k];
    end else if (busy_q) begin
      rem_q <= rem_q & ~take;
      if (grp_done) busy_q <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  a_r11_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> in_wcode <= 3'd4);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !in_ready);

  a_r2_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> in_ready);

  a_r6_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask != '0) && ((txn_mask & ~rem_q) == '0));

  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !grp_done) |=> (rem_q & $past(txn_mask)) == '0);

  a_r5_leader_served: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask & lead_oh) != '0);

  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> align_down(txn_base, txn_lg) == txn_base);

  a_r3_size_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !strict_q) |-> (txn_lg >= 4'(MIN_LG)) && (txn_lg <= sglg));

  a_r8_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && strict_q && !sok_q) |-> $countones(txn_mask) == 1);
endmodule

// File: tb/mcoal_top_test.sv
`timescale 1ns/1ps
module mcoal_top_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_addr = '0;
  logic [15:0]  in_mask = '0;
  logic [2:0]   in_wcode = '0;
  logic         in_strict = 1'b0;
  logic         txn_valid;
  logic [31:0]  txn_base;
  logic [3:0]   txn_lg;
  logic [15:0]  txn_mask;
  logic         grp_done;

  int checks = 0;
  int errors = 0;

  logic [31:0] s_addr [16];
  logic [31:0] e_base [16];
  logic [3:0]  e_lg   [16];
  logic [15:0] e_mask [16];
  int          e_n;

  always #4 clk = ~clk;

  mcoal_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .in_wcode(in_wcode), .in_strict(in_strict),
    .txn_valid(txn_valid), .txn_base(txn_base), .txn_lg(txn_lg),
    .txn_mask(txn_mask), .grp_done(grp_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_exp();
    e_n = 0;
  endtask

  task automatic add_exp(input logic [31:0] b, input logic [3:0] lg, input logic [15:0] m);
    e_base[e_n] = b; e_lg[e_n] = lg; e_mask[e_n] = m;
    e_n++;
  endtask

  task automatic run_group(input string req, input logic [15:0] m,
                           input logic [2:0] wc, input bit strict);
    int  n;
    bit  got_done;
    n = 0;
    got_done = 0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "ready before group", in_ready, 1);
    for (int k = 0; k < 16; k++) in_addr[k*32 +: 32] = s_addr[k];
    in_mask = m; in_wcode = wc; in_strict = strict; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 40 && !got_done; c++) begin
      if (c > 0) @(negedge clk);
      chk(in_ready == 1'b0, "R2", "ready while busy", in_ready, 0);
      if (txn_valid) begin
        if (n < e_n) begin
          chk(txn_base == e_base[n], req, "txn base", txn_base, e_base[n]);
          chk(txn_lg == e_lg[n], req, "txn size", txn_lg, e_lg[n]);
          chk(txn_mask == e_mask[n], req, "txn mask", txn_mask, e_mask[n]);
          chk(grp_done == (n == e_n - 1), "R10", "done vs last", grp_done, (n == e_n - 1));
        end else begin
          chk(1'b0, "R6", "extra transaction", n, e_n);
        end
        n++;
      end
      if (grp_done) got_done = 1;
    end
    chk(got_done, "R10", "done seen", got_done, 1);
    chk(n == e_n, "R6", "transaction count", n, e_n);
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "ready after done", in_ready, 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "reset ready", in_ready, 1);
    chk(txn_valid == 1'b0, "R1", "reset txn_valid", txn_valid, 0);
    chk(grp_done == 1'b0, "R1", "reset done", grp_done, 0);
  endtask

  task automatic t_relaxed_linear();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h1000 + 4*k;
    clr_exp(); add_exp(32'h1000, 4'd6, 16'hFFFF);
    run_group("R4", 16'hFFFF, 3'd2, 1'b0);
  endtask

  task automatic t_relaxed_reversed();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h2000 + 4*(15 - k);
    clr_exp(); add_exp(32'h2000, 4'd6, 16'hFFFF);
    run_group("R3", 16'hFFFF, 3'd2, 1'b0);
  endtask

  task automatic t_relaxed_two_segs();
    for (int k = 0; k < 8; k++)  s_addr[k] = 32'h3000 + 4*k;
    for (int k = 8; k < 16; k++) s_addr[k] = 32'h3080 + 4*(k - 8);
    clr_exp(); add_exp(32'h3000, 4'd5, 16'h00FF); add_exp(32'h3080, 4'd5, 16'hFF00);
    run_group("R5", 16'hFFFF, 3'd2, 1'b0);
  endtask

  task automatic t_relaxed_interleaved();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h0BAD_0000 + 64*k;
    s_addr[0] = 32'h6080; s_addr[1] = 32'h6000; s_addr[2] = 32'h6084; s_addr[3] = 32'h6004;
    clr_exp(); add_exp(32'h6080, 4'd5, 16'h0005); add_exp(32'h6000, 4'd5, 16'h000A);
    run_group("R5", 16'h000F, 3'd2, 1'b0);
  endtask

  task automatic t_relaxed_bytes();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h7010 + k;
    clr_exp(); add_exp(32'h7000, 4'd5, 16'hFFFF);
    run_group("R3", 16'hFFFF, 3'd0, 1'b0);
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h7018 + k;
    clr_exp(); add_exp(32'h7000, 4'd5, 16'h00FF); add_exp(32'h7020, 4'd5, 16'hFF00);
    run_group("R3", 16'hFFFF, 3'd0, 1'b0);
  endtask

  task automatic t_relaxed_halfwords();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h8010 + 2*k;
    clr_exp(); add_exp(32'h8000, 4'd6, 16'hFFFF);
    run_group("R3", 16'hFFFF, 3'd1, 1'b0);
  endtask

  task automatic t_relaxed_dwords();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h9000 + 8*k;
    clr_exp(); add_exp(32'h9000, 4'd7, 16'hFFFF);
    run_group("R4", 16'hFFFF, 3'd3, 1'b0);
  endtask

  task automatic t_sparse_lowbits();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'h5555_0000 + 256*k;
    s_addr[0] = 32'hA003; s_addr[8] = 32'hA041;
    clr_exp(); add_exp(32'hA000, 4'd7, 16'h0101);
    run_group("R11", 16'h0101, 3'd2, 1'b0);
  endtask

  task automatic t_strict_merge();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'hB000 + 4*k;
    clr_exp(); add_exp(32'hB000, 4'd6, 16'h00F0);
    run_group("R7", 16'h00F0, 3'd2, 1'b1);
    for (int k = 0; k < 16; k++) s_addr[k] = 32'hC000 + 16*k;
    clr_exp(); add_exp(32'hC000, 4'd8, 16'hFFFF);
    run_group("R7", 16'hFFFF, 3'd4, 1'b1);
  endtask

  task automatic t_strict_permuted();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'hD000 + 4*k;
    s_addr[0] = 32'hD004; s_addr[1] = 32'hD000;
    clr_exp();
    add_exp(32'hD004, 4'd2, 16'h0001); add_exp(32'hD000, 4'd2, 16'h0002);
    add_exp(32'hD008, 4'd2, 16'h0004); add_exp(32'hD00C, 4'd2, 16'h0008);
    run_group("R8", 16'h000F, 3'd2, 1'b1);
  endtask

  task automatic t_strict_misaligned();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'hE004 + 4*k;
    clr_exp();
    for (int k = 0; k < 16; k++) add_exp(32'hE004 + 4*k, 4'd2, 16'(1 << k));
    run_group("R8", 16'hFFFF, 3'd2, 1'b1);
  endtask

  task automatic t_empty();
    for (int k = 0; k < 16; k++) s_addr[k] = 32'hF000 + 4*k;
    clr_exp();
    run_group("R9", 16'h0000, 3'd2, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_relaxed_linear();
    t_relaxed_reversed();
    t_relaxed_two_segs();
    t_relaxed_interleaved();
    t_relaxed_bytes();
    t_relaxed_halfwords();
    t_relaxed_dwords();
    t_sparse_lowbits();
    t_strict_merge();
    t_strict_permuted();
    t_strict_misaligned();
    t_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule